// File: doc/BRIEF.md
# Streaming Memory and Register Read Ports

This block gives a small microcontroller two streaming data sources, both read through one data-register read strobe. A select input picks the source. The memory source fetches the 32-bit word at a 64-bit read address. The register source fetches the word at a register index. Firmware loads a start address and a word count into control registers. It then reads the data register repeatedly, and each consuming read moves the stream forward by one word. A peek read returns the same word without moving anything.

The memory address has a privileged mode. When the top bit of the privileged high register is set, that register supplies the upper half of the effective address. The low half of the programmed read address then advances on its own and wraps inside a 4 GB window.

While a fetch is in flight the block raises a busy flag. The data arrives with a one-cycle valid pulse. A register index outside the implemented register space never reaches the register interface and reads back as zero.

Top module: `strm_rd_ports`

## Requirements
- R1: After reset, rd_busy, rd_valid, mem_req and reg_req are low. The memory address, both counts, the privileged register and the register index all hold zero.
- R2: Control writes use cfg_idx to choose the target: 0 is memory address low, 1 is memory address high, 2 is memory word count, 3 is privileged high, 4 is register index and 5 is register word count. Writes to indices 6 and 7 change nothing.
- R3: A consuming memory read (rd_sel=0, rd_peek=0) returns the word at the effective address. If the memory count is non-zero, the read lowers the count by 1 and adds 4 to the 64-bit read address, with carry into the high half.
- R4: A consuming register read (rd_sel=1, rd_peek=0) returns the word at the register index. If the register count is non-zero, the read lowers the count by 1 and adds 1 to the index.
- R5: A peek read (rd_peek=1) returns the current word from either source and leaves that source's count and address unchanged.
- R6: When a source's count is zero, a consuming read still returns the word at the current address, and neither the count nor the address changes.
- R7: When bit 31 of the privileged high register is set, the effective memory address is {1'b0, priv[30:0], addr_lo}. An advance then adds 4 to addr_lo only, wrapping modulo 2^32, and leaves addr_hi as it was.
- R8: The block accepts a strobe only while rd_busy is low. rd_busy rises on the next cycle, and the source request is a one-cycle pulse in that same cycle. rd_valid is a one-cycle pulse with rd_busy low, issued on the cycle after the response.
- R9: A register index at or above REG_SPACE raises no reg_req and returns zero. The index and count still advance as in R4.
- R10: Exactly one source is requested per strobe: rd_sel=0 raises only mem_req, and rd_sel=1 raises only reg_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_idx | input | 3 | Control register index |
| cfg_wdata | input | 32 | Control register write data |
| rd_stb | input | 1 | Data register read strobe |
| rd_sel | input | 1 | Source select: 0 memory, 1 register |
| rd_peek | input | 1 | Read without advancing |
| rd_busy | output | 1 | Fetch in flight |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 32 | Read data |
| mem_req | output | 1 | Memory read request pulse |
| mem_addr | output | 64 | Effective memory byte address |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_data | input | 32 | Memory response word |
| reg_req | output | 1 | Register read request pulse |
| reg_addr | output | RA_W (6) | Register index |
| reg_rsp_valid | input | 1 | Register response valid |
| reg_rsp_data | input | 32 | Register response word |

## Verification
A wrong count or address does not show in the data of the read that caused it. It shows on the next request, as a wrong mem_addr or reg_addr and a wrong returned word. The bench therefore peeks before every consuming read and compares the request address each time. This catches a bad advance within one read, which is about four cycles. A count that fails to stop at zero keeps the address moving past the end of the stream, and the sweeps read beyond the programmed count to expose it. A sequencing fault shows at once as a missing or doubled request pulse, or as rd_valid rising while busy.

// File: rtl/strm_rd_pkg.sv
package strm_rd_pkg;
  localparam int DW       = 32;
  localparam int CR_IDX_W = 3;
  localparam int MEM_STEP = 4;

  typedef enum logic [CR_IDX_W-1:0] {
    CR_MEM_LO  = 3'd0,
    CR_MEM_HI  = 3'd1,
    CR_MEM_CNT = 3'd2,
    CR_PRIV_HI = 3'd3,
    CR_REG_ADR = 3'd4,
    CR_REG_CNT = 3'd5
  } cr_idx_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } rd_state_e;

  typedef struct packed {
    logic sel;
    logic peek;
  } rd_cmd_t;
endpackage

// File: rtl/strm_cfg_regs.sv
module strm_cfg_regs
  import strm_rd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CR_IDX_W-1:0] cfg_idx,
  input  logic [DW-1:0]       cfg_wdata,
  input  logic                adv_mem,
  input  logic                adv_reg,
  input  logic [DW-1:0]       nxt_mem_lo,
  input  logic [DW-1:0]       nxt_mem_hi,
  input  logic [DW-1:0]       nxt_reg_adr,
  output logic [DW-1:0]       mem_lo,
  output logic [DW-1:0]       mem_hi,
  output logic [DW-1:0]       mem_cnt,
  output logic [DW-1:0]       priv_hi,
  output logic [DW-1:0]       reg_adr,
  output logic [DW-1:0]       reg_cnt
);
  logic [DW-1:0] mem_lo_n, mem_hi_n, mem_cnt_n, priv_hi_n, reg_adr_n, reg_cnt_n;
  logic          en;

  always_comb begin
    mem_lo_n  = mem_lo;
    mem_hi_n  = mem_hi;
    mem_cnt_n = mem_cnt;
    priv_hi_n = priv_hi;
    reg_adr_n = reg_adr;
    reg_cnt_n = reg_cnt;
    if (adv_mem) begin
      mem_lo_n  = nxt_mem_lo;
      mem_hi_n  = nxt_mem_hi;
      mem_cnt_n = mem_cnt - DW'(1);
    end
    if (adv_reg) begin
      reg_adr_n = nxt_reg_adr;
      reg_cnt_n = reg_cnt - DW'(1);
    end
    // a control write in the same cycle overrides the advance
    if (cfg_we) begin
      case (cfg_idx)
        CR_MEM_LO:  mem_lo_n  = cfg_wdata;
        CR_MEM_HI:  mem_hi_n  = cfg_wdata;
        CR_MEM_CNT: mem_cnt_n = cfg_wdata;
        CR_PRIV_HI: priv_hi_n = cfg_wdata;
        CR_REG_ADR: reg_adr_n = cfg_wdata;
        CR_REG_CNT: reg_cnt_n = cfg_wdata;
        default: ;
      endcase
    end
  end

  assign en = cfg_we | adv_mem | adv_reg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_lo  <= '0;
      mem_hi  <= '0;
      mem_cnt <= '0;
      priv_hi <= '0;
      reg_adr <= '0;
      reg_cnt <= '0;
    end else if (en) begin
      mem_lo  <= mem_lo_n;
      mem_hi  <= mem_hi_n;
      mem_cnt <= mem_cnt_n;
      priv_hi <= priv_hi_n;
      reg_adr <= reg_adr_n;
      reg_cnt <= reg_cnt_n;
    end
  end
endmodule

// File: rtl/strm_addr_gen.sv
module strm_addr_gen
  import strm_rd_pkg::*;
#(
  parameter int REG_SPACE = 64
) (
  input  logic [DW-1:0]   mem_lo,
  input  logic [DW-1:0]   mem_hi,
  input  logic [DW-1:0]   priv_hi,
  input  logic [DW-1:0]   reg_adr,
  output logic [2*DW-1:0] eff_addr,
  output logic [DW-1:0]   nxt_mem_lo,
  output logic [DW-1:0]   nxt_mem_hi,
  output logic [DW-1:0]   nxt_reg_adr,
  output logic            reg_in_range
);
  logic            priv_on;
  logic [2*DW-1:0] lin_sum;

  assign priv_on  = priv_hi[DW-1];
  assign eff_addr = priv_on ? {1'b0, priv_hi[DW-2:0], mem_lo} : {mem_hi, mem_lo};
  assign lin_sum  = {mem_hi, mem_lo} + (2*DW)'(MEM_STEP);

  // low half advances the same way in both modes; only the carry differs
  assign nxt_mem_lo   = lin_sum[DW-1:0];
  assign nxt_mem_hi   = priv_on ? mem_hi : lin_sum[2*DW-1:DW];
  assign nxt_reg_adr  = reg_adr + DW'(1);
  assign reg_in_range = (reg_adr < DW'(REG_SPACE));
endmodule

// File: rtl/strm_rd_fsm.sv
module strm_rd_fsm
  import strm_rd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_stb,
  input  logic          rd_sel,
  input  logic          rd_peek,
  input  logic          mem_cnt_nz,
  input  logic          reg_cnt_nz,
  input  logic          reg_in_range,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  input  logic          reg_rsp_valid,
  input  logic [DW-1:0] reg_rsp_data,
  output logic          mem_req,
  output logic          reg_req,
  output logic          rd_busy,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          adv_mem,
  output logic          adv_reg
);
  rd_state_e     state, state_n;
  rd_cmd_t       cmd, cmd_n;
  logic          valid_n;
  logic [DW-1:0] data_n;
  logic          done;
  logic [DW-1:0] done_data;

  always_comb begin
    state_n   = state;
    cmd_n     = cmd;
    done      = 1'b0;
    done_data = '0;
    case (state)
      ST_IDLE: begin
        if (rd_stb) begin
          cmd_n   = '{sel: rd_sel, peek: rd_peek};
          state_n = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (cmd.sel && !reg_in_range) begin
          done    = 1'b1;
          state_n = ST_IDLE;
        end else begin
          state_n = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (cmd.sel ? reg_rsp_valid : mem_rsp_valid) begin
          done      = 1'b1;
          done_data = cmd.sel ? reg_rsp_data : mem_rsp_data;
          state_n   = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
    valid_n = done;
    data_n  = done ? done_data : rd_data;
  end

  assign mem_req = (state == ST_ISSUE) && !cmd.sel;
  assign reg_req = (state == ST_ISSUE) && cmd.sel && reg_in_range;
  assign rd_busy = (state != ST_IDLE);
  assign adv_mem = done && !cmd.peek && !cmd.sel && mem_cnt_nz;
  assign adv_reg = done && !cmd.peek && cmd.sel && reg_cnt_nz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cmd      <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      state    <= state_n;
      rd_valid <= valid_n;
      if (state == ST_IDLE) cmd <= cmd_n;
      if (done) rd_data <= data_n;
    end
  end
endmodule

// File: rtl/strm_rd_ports.sv
module strm_rd_ports
  import strm_rd_pkg::*;
#(
  parameter int REG_SPACE = 64,
  localparam int RA_W = (REG_SPACE > 1) ? $clog2(REG_SPACE) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CR_IDX_W-1:0] cfg_idx,
  input  logic [DW-1:0]       cfg_wdata,
  input  logic                rd_stb,
  input  logic                rd_sel,
  input  logic                rd_peek,
  output logic                rd_busy,
  output logic                rd_valid,
  output logic [DW-1:0]       rd_data,
  output logic                mem_req,
  output logic [2*DW-1:0]     mem_addr,
  input  logic                mem_rsp_valid,
  input  logic [DW-1:0]       mem_rsp_data,
  output logic                reg_req,
  output logic [RA_W-1:0]     reg_addr,
  input  logic                reg_rsp_valid,
  input  logic [DW-1:0]       reg_rsp_data
);
  logic [1:0]    rst_sync;
  logic          rst_core_n;
  logic [DW-1:0] mem_lo, mem_hi, mem_cnt, priv_hi, reg_adr, reg_cnt;
  logic [DW-1:0] nxt_mem_lo, nxt_mem_hi, nxt_reg_adr;
  logic          reg_in_range, adv_mem, adv_reg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  strm_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_core_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .adv_mem(adv_mem), .adv_reg(adv_reg),
    .nxt_mem_lo(nxt_mem_lo), .nxt_mem_hi(nxt_mem_hi), .nxt_reg_adr(nxt_reg_adr),
    .mem_lo(mem_lo), .mem_hi(mem_hi), .mem_cnt(mem_cnt),
    .priv_hi(priv_hi), .reg_adr(reg_adr), .reg_cnt(reg_cnt)
  );

  strm_addr_gen #(.REG_SPACE(REG_SPACE)) u_agen (
    .mem_lo(mem_lo), .mem_hi(mem_hi), .priv_hi(priv_hi), .reg_adr(reg_adr),
    .eff_addr(mem_addr), .nxt_mem_lo(nxt_mem_lo), .nxt_mem_hi(nxt_mem_hi),
    .nxt_reg_adr(nxt_reg_adr), .reg_in_range(reg_in_range)
  );

  strm_rd_fsm u_fsm (
    .clk(clk), .rst_n(rst_core_n),
    .rd_stb(rd_stb), .rd_sel(rd_sel), .rd_peek(rd_peek),
    .mem_cnt_nz(mem_cnt != '0), .reg_cnt_nz(reg_cnt != '0),
    .reg_in_range(reg_in_range),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .reg_rsp_valid(reg_rsp_valid), .reg_rsp_data(reg_rsp_data),
    .mem_req(mem_req), .reg_req(reg_req), .rd_busy(rd_busy),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .adv_mem(adv_mem), .adv_reg(adv_reg)
  );

  assign reg_addr = reg_adr[RA_W-1:0];
endmodule

// File: rtl/strm_rd_ports_chk.sv
module strm_rd_ports_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_stb,
  input logic rd_busy,
  input logic rd_valid,
  input logic mem_req,
  input logic reg_req
);
  p_req_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req, reg_req}));

  p_busy_after_stb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !rd_busy) |=> rd_busy);

  p_req_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || reg_req) |=> !(mem_req || reg_req));

  p_valid_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !rd_busy);

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_req_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || reg_req) |-> rd_busy);
endmodule

bind strm_rd_ports strm_rd_ports_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_busy(rd_busy),
  .rd_valid(rd_valid), .mem_req(mem_req), .reg_req(reg_req)
);

// File: tb/strm_rd_ports_tb_top.sv
`timescale 1ns/1ps
module strm_rd_ports_tb_top;
  localparam int REG_SPACE = 64;
  localparam int RA_W = 6;

  logic        clk, rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic [31:0] cfg_wdata;
  logic        rd_stb, rd_sel, rd_peek;
  logic        rd_busy, rd_valid;
  logic [31:0] rd_data;
  logic        mem_req;
  logic [63:0] mem_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        reg_req;
  logic [RA_W-1:0] reg_addr;
  logic        reg_rsp_valid;
  logic [31:0] reg_rsp_data;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  int          n_mreq = 0, n_rreq = 0;
  logic [63:0] last_maddr;
  logic [31:0] last_raddr;

  logic [31:0] e_mlo, e_mhi, e_mcnt, e_priv, e_radr, e_rcnt;

  strm_rd_ports #(.REG_SPACE(REG_SPACE)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .rd_stb(rd_stb), .rd_sel(rd_sel), .rd_peek(rd_peek),
    .rd_busy(rd_busy), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .reg_req(reg_req), .reg_addr(reg_addr),
    .reg_rsp_valid(reg_rsp_valid), .reg_rsp_data(reg_rsp_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] mem_model(input logic [63:0] a);
    return a[31:0] ^ (a[63:32] * 32'h9E37_79B1) ^ 32'h0A5A_0000;
  endfunction

  function automatic logic [31:0] reg_model(input logic [31:0] a);
    return a * 32'd7 + 32'h55;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  // response model: one cycle after a request, drive the answer for one cycle
  initial begin
    bit pm, pr;
    logic [63:0] pma;
    logic [31:0] pra;
    pm = 0; pr = 0; pma = '0; pra = '0;
    mem_rsp_valid = 0; mem_rsp_data = '0;
    reg_rsp_valid = 0; reg_rsp_data = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0;
      reg_rsp_valid = 0;
      if (pm) begin mem_rsp_valid = 1; mem_rsp_data = mem_model(pma); pm = 0; end
      if (pr) begin reg_rsp_valid = 1; reg_rsp_data = reg_model(pra); pr = 0; end
      if (mem_req) begin pm = 1; pma = mem_addr; last_maddr = mem_addr; n_mreq++; end
      if (reg_req) begin pr = 1; pra = 32'(reg_addr); last_raddr = 32'(reg_addr); n_rreq++; end
    end
  end

  task automatic cfg_wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    case (idx)
      3'd0: e_mlo  = d;
      3'd1: e_mhi  = d;
      3'd2: e_mcnt = d;
      3'd3: e_priv = d;
      3'd4: e_radr = d;
      3'd5: e_rcnt = d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic sel, input logic peek, input string req);
    logic [63:0] ea;
    logic [31:0] ed, got;
    int nm0, nr0;
    bit inr, seen;
    nm0 = n_mreq; nr0 = n_rreq;
    inr = (e_radr < REG_SPACE);
    if (!sel) begin
      ea = e_priv[31] ? {1'b0, e_priv[30:0], e_mlo} : {e_mhi, e_mlo};
      ed = mem_model(ea);
    end else begin
      ea = {32'h0, e_radr};
      ed = inr ? reg_model(e_radr) : 32'h0;
    end
    @(negedge clk);
    rd_stb = 1; rd_sel = sel; rd_peek = peek;
    @(negedge clk);
    rd_stb = 0;
    chk(rd_busy == 1'b1, "R8 busy", 64'(rd_busy), 64'h1);
    seen = 0; got = '0;
    for (int i = 0; i < 20; i++) begin
      if (rd_valid) begin seen = 1; got = rd_data; break; end
      @(negedge clk);
    end
    chk(seen, "R8 valid", 64'(seen), 64'h1);
    chk(rd_busy == 1'b0, "R8 idle at valid", 64'(rd_busy), 64'h0);
    chk(got == ed, req, 64'(got), 64'(ed));
    if (!sel) begin
      chk(n_mreq == nm0 + 1 && n_rreq == nr0, "R10 mem req", 64'(n_mreq - nm0), 64'h1);
      chk(last_maddr == ea, req, last_maddr, ea);
    end else begin
      chk(n_rreq == nr0 + int'(inr) && n_mreq == nm0, inr ? "R10 reg req" : "R9 no req",
          64'(n_rreq - nr0), 64'(inr));
      if (inr) chk(last_raddr == e_radr, req, 64'(last_raddr), 64'(e_radr));
    end
    if (!peek) begin
      if (!sel && e_mcnt != 0) begin
        e_mcnt--;
        if (e_priv[31]) e_mlo = e_mlo + 32'd4;
        else {e_mhi, e_mlo} = {e_mhi, e_mlo} + 64'd4;
      end
      if (sel && e_rcnt != 0) begin
        e_rcnt--;
        e_radr = e_radr + 32'd1;
      end
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] bases [3];
    rst_n = 0; cfg_we = 0; cfg_idx = '0; cfg_wdata = '0;
    rd_stb = 0; rd_sel = 0; rd_peek = 0;
    last_maddr = '0; last_raddr = '0;
    e_mlo = 0; e_mhi = 0; e_mcnt = 0; e_priv = 0; e_radr = 0; e_rcnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: quiet outputs and zeroed state after reset
    chk(!rd_busy && !rd_valid, "R1 flags", {62'h0, rd_busy, rd_valid}, 64'h0);
    chk(!mem_req && !reg_req, "R1 reqs", {62'h0, mem_req, reg_req}, 64'h0);
    chk(mem_addr == 64'h0, "R1 addr", mem_addr, 64'h0);
    rd(1'b0, 1'b0, "R1 R6 mem at reset");
    rd(1'b0, 1'b0, "R1 R6 mem no advance");
    rd(1'b1, 1'b0, "R1 R6 reg at reset");

    // R3 R5 R6: linear streams, including a carry across the 32-bit boundary
    bases[0] = 32'h0000_1000;
    bases[1] = 32'hFFFF_FFF8;
    bases[2] = 32'h7FFF_FFFC;
    for (int b = 0; b < 3; b++) begin
      cfg_wr(3'd0, bases[b]);
      cfg_wr(3'd1, 32'h5 + 32'(b));
      cfg_wr(3'd2, 32'd3);
      for (int k = 0; k < 5; k++) begin
        rd(1'b0, 1'b1, "R5 mem peek");
        rd(1'b0, 1'b0, (k < 3) ? "R3 mem consume" : "R6 mem count zero");
      end
    end

    // R7: privileged upper half, low half wraps inside 4 GB
    cfg_wr(3'd0, 32'hFFFF_FFF8);
    cfg_wr(3'd1, 32'h0000_0777);
    cfg_wr(3'd3, 32'h8000_0012);
    cfg_wr(3'd2, 32'd4);
    for (int k = 0; k < 5; k++) begin
      rd(1'b0, 1'b1, "R7 priv peek");
      rd(1'b0, 1'b0, "R7 priv consume");
    end
    chk(mem_addr == {32'h12, e_mlo}, "R7 wrap addr", mem_addr, {32'h12, e_mlo});
    cfg_wr(3'd3, 32'h0000_0012);
    rd(1'b0, 1'b0, "R7 priv bit clear");

    // R2: writes to unused indices leave every register alone
    cfg_wr(3'd6, 32'hDEAD_BEEF);
    cfg_wr(3'd7, 32'h1234_5678);
    rd(1'b0, 1'b1, "R2 unused index mem");
    rd(1'b1, 1'b1, "R2 unused index reg");

    // R4 R9: register stream across the end of the implemented space
    cfg_wr(3'd4, 32'(REG_SPACE - 3));
    cfg_wr(3'd5, 32'd5);
    for (int k = 0; k < 7; k++) begin
      rd(1'b1, 1'b1, "R5 reg peek");
      rd(1'b1, 1'b0, (e_radr < REG_SPACE) ? "R4 reg consume" : "R9 reg out of range");
    end
    cfg_wr(3'd4, 32'd10);
    cfg_wr(3'd5, 32'd2);
    for (int k = 0; k < 3; k++) rd(1'b1, 1'b0, "R4 reg low range");

    done = 1;
    finish_run();
  end
endmodule